// File: doc/BRIEF.md
# Page-copy DMA bus master

This engine sits next to a storage controller and moves one page of main memory into the controller's local buffer without the processor's involvement. The processor starts it with a single command write. The write carries a device identifier, an operation code and the physical byte address of the page. The engine only takes the command if the identifier matches its own fixed identifier and it is not already busy.

After it accepts a command, the engine asks for the system bus and waits for a grant. While it owns the bus, it reads the page one word at a time over a valid/ready read port. Each returned word goes into the local buffer at a fixed base address plus a running word offset. The main-memory address steps by four bytes for every word moved. When the last word is stored, the engine releases the bus, pulses a completion strobe and sets a sticky status flag. The flag stays set until the next accepted command.

The low bit of the operation code is latched as a direction indicator. The copy itself always runs from memory to the buffer.

Top module: `page_dma`

## Requirements
- R1: While reset is asserted and right after it, bus_req, mem_rd, buf_we, done and status are all low.
- R2: A command (cmd_valid high) is accepted only when cmd_dev equals the DEV_ID parameter and the engine is idle. After an accepted command, bus_req is high from the next cycle.
- R3: mem_rd is never high unless both bus_gnt and bus_req are high, so no memory read is issued before the grant.
- R4: The first read address equals cmd_addr with bits [1:0] forced to zero. The address rises by 4 after every transferred word and holds steady while a read waits for mem_ready.
- R5: A word is transferred only in a cycle where mem_rd and mem_ready are both high. In that same cycle buf_we is high, buf_wdata equals mem_rdata, and buf_addr equals BUF_BASE plus the word offset. The offset runs 0, 1, … PAGE_WORDS-1.
- R6: bus_req stays high from acceptance through the cycle of the last transfer and is low in the following cycle.
- R7: done is high for exactly one cycle, the cycle after the last transfer. status rises in that same cycle, stays high, and is low from the cycle after the next accepted command.
- R8: A command that arrives while a transfer is in progress, or that carries a different device identifier, is ignored. Neither the address sequence nor the bus request changes.
- R9: Output dir holds bit 0 of cmd_op from the most recently accepted command, starting the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe from the processor |
| cmd_dev | input | DEV_W | Target device identifier |
| cmd_op | input | 2 | Operation code; bit 0 is the direction bit |
| cmd_addr | input | 32 | Physical byte address of the page |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_rd | output | 1 | Read request valid toward main memory |
| mem_addr | output | 32 | Read byte address |
| mem_ready | input | 1 | Read data valid from main memory |
| mem_rdata | input | 32 | Read data |
| buf_we | output | 1 | Local buffer write enable |
| buf_addr | output | BUF_AW | Local buffer word address |
| buf_wdata | output | 32 | Local buffer write data |
| dir | output | 1 | Latched direction bit |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | Sticky completion flag |

## Verification
The assertions assume that the arbiter keeps bus_gnt high from the moment it is given until bus_req falls. They also assume that memory only raises mem_ready against a pending read. The bench's arbiter model grants a few cycles after the request and withdraws the grant only once the request drops. The memory model produces data that is a fixed function of the address and answers with an irregular ready pattern, so stalls appear in the middle of the page. Extra commands are injected during a transfer and with a foreign identifier, and the bench confirms that the word stream does not change.

// File: rtl/page_dma.sv
module page_dma #(
  parameter int DEV_W      = 8,
  parameter int DEV_ID     = 8'h2C,
  parameter int PAGE_WORDS = 1024,
  parameter int BUF_AW     = 12,
  parameter int BUF_BASE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [1:0]        cmd_op,
  input  logic [31:0]       cmd_addr,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_rd,
  output logic [31:0]       mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [31:0]       buf_wdata,
  output logic              dir,
  output logic              done,
  output logic              status
);
  localparam int OFFW = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam logic [BUF_AW-1:0] BASE = BUF_AW'(BUF_BASE);
  localparam logic [OFFW-1:0] LAST_OFF = OFFW'(PAGE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} state_t;
  state_t st;
  logic [31:0] addr_q;
  logic [OFFW-1:0] off_q;

  wire accept = cmd_valid && (cmd_dev == DEV_W'(DEV_ID)) && (st == S_IDLE);
  wire hs     = mem_rd && mem_ready;
  wire last   = off_q == LAST_OFF;

  assign bus_req   = st != S_IDLE;
  assign mem_rd    = (st == S_XFER) && bus_gnt;
  assign mem_addr  = addr_q;
  assign buf_we    = hs;
  assign buf_wdata = mem_rdata;
  assign buf_addr  = BASE + BUF_AW'(off_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      off_q  <= '0;
      dir    <= 1'b0;
      done   <= 1'b0;
      status <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_REQ;
          addr_q <= {cmd_addr[31:2], 2'b00};
          off_q  <= '0;
          dir    <= cmd_op[0];
          status <= 1'b0;
        end
        S_REQ: if (bus_gnt) st <= S_XFER;
        S_XFER: if (hs) begin
          addr_q <= addr_q + 32'd4;
          off_q  <= off_q + 1'b1;
          if (last) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            status <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_rd_owns_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_gnt && bus_req));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last) |=> (mem_addr == $past(mem_addr) + 32'd4));
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status);
endmodule

// File: tb/page_dma_bench.sv
`timescale 1ns/1ps
module page_dma_bench;
  localparam int PW = 8;
  localparam int AW = 8;
  localparam int BB = 16;
  localparam int ID = 8'h2C;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_dev = 0;
  logic [1:0] cmd_op = 0;
  logic [31:0] cmd_addr = 0;
  logic bus_req, bus_gnt = 0, mem_rd, mem_ready = 0, buf_we, dir, done, status;
  logic [31:0] mem_addr, mem_rdata, buf_wdata;
  logic [AW-1:0] buf_addr;

  int checks = 0, fails = 0;
  logic [31:0] q_maddr[$];
  logic [AW-1:0] q_baddr[$];
  int words = 0, gnt_wait = 0, r3_viol = 0, dones = 0;
  logic expect_done = 0;
  logic [7:0] lfsr = 8'h5B;

  always #5 clk = ~clk;

  page_dma #(.PAGE_WORDS(PW), .BUF_AW(AW), .BUF_BASE(BB), .DEV_ID(ID)) u_page_dma (.*);

  assign mem_rdata = mem_addr ^ 32'hC3A5_0F0F;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // arbiter and memory models, driven after the edge
  always @(posedge clk) begin
    #2;
    if (!bus_req) begin bus_gnt = 0; gnt_wait = 0; end
    else begin gnt_wait++; if (gnt_wait >= 3) bus_gnt = 1; end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = lfsr[0] | lfsr[2];
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (mem_rd && !(bus_gnt && bus_req)) r3_viol++;
    if (expect_done) begin
      chk(done === 1'b1, "R7 done pulse", {31'd0, done}, 1);
      chk(bus_req === 1'b0, "R6 bus released", {31'd0, bus_req}, 0);
      chk(status === 1'b1, "R7 status set", {31'd0, status}, 1);
      dones++;
      expect_done = 0;
    end else if (done) chk(0, "R7 unexpected done", 1, 0);
    if (buf_we) begin
      if (q_maddr.size() == 0) chk(0, "R5 extra word", {24'd0, buf_addr}, 0);
      else begin
        logic [31:0] ea;
        logic [AW-1:0] eb;
        ea = q_maddr.pop_front();
        eb = q_baddr.pop_front();
        chk(mem_addr === ea, "R4 read address", mem_addr, ea);
        chk(buf_addr === eb, "R5 buffer address", {24'd0, buf_addr}, {24'd0, eb});
        chk(buf_wdata === (ea ^ 32'hC3A5_0F0F), "R5 buffer data", buf_wdata, ea ^ 32'hC3A5_0F0F);
        words++;
        if (q_maddr.size() == 0) expect_done = 1;
      end
    end else if (words > 0 && words < PW) begin
      chk(bus_req === 1'b1, "R6 request held", {31'd0, bus_req}, 1);
    end
  end

  task automatic send(input logic [7:0] dev, input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_dev = dev; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic run(input logic [31:0] a, input logic [1:0] op, input bit inject);
    words = 0;
    for (int i = 0; i < PW; i++) begin
      q_maddr.push_back({a[31:2], 2'b00} + 32'(4 * i));
      q_baddr.push_back(AW'(BB + i));
    end
    send(8'(ID), op, a);
    chk(bus_req === 1'b1, "R2 request after accept", {31'd0, bus_req}, 1);
    chk(status === 1'b0, "R7 status cleared", {31'd0, status}, 0);
    chk(dir === op[0], "R9 direction latched", {31'd0, dir}, {31'd0, op[0]});
    if (inject) begin
      repeat (6) @(negedge clk);
      send(8'(ID), ~op, 32'h0BAD_0000);
      chk(dir === op[0], "R8 busy command ignored", {31'd0, dir}, {31'd0, op[0]});
    end
    for (int k = 0; k < 400 && !(words == PW && !expect_done); k++) @(negedge clk);
    chk(words == PW && q_maddr.size() == 0, "R5 page length", 32'(words), PW);
    @(negedge clk);
    chk(status === 1'b1 && bus_req === 1'b0, "R7 status sticky", {31'd0, status}, 1);
  endtask

  initial begin
    #10000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!bus_req && !mem_rd && !buf_we && !done && !status, "R1 reset state",
        {27'd0, bus_req, mem_rd, buf_we, done, status}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !status, "R1 after reset", {30'd0, bus_req, status}, 0);
    send(8'h11, 2'b01, 32'h0000_4000);
    repeat (4) @(negedge clk);
    chk(bus_req === 1'b0 && !mem_rd, "R8 foreign id ignored", {31'd0, bus_req}, 0);
    chk(bus_gnt === 1'b0, "R2 no grant without request", {31'd0, bus_gnt}, 0);
    run(32'h0001_2003, 2'b01, 1'b0);
    run(32'h8000_0ff0, 2'b10, 1'b1);
    run(32'hFFFF_FFE1, 2'b11, 1'b1);
    chk(r3_viol == 0, "R3 reads only under grant", 32'(r3_viol), 0);
    chk(dones == 3, "R7 one done per page", 32'(dones), 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule